// File: doc/BRIEF.md
# Trigger-Level Byte FIFO with DMA Request Lines

This block is a byte queue of up to sixteen entries placed between a serial engine and a bus or DMA master. A writer pushes bytes on one side and a reader pops them on the other. Full and empty flags report its state. A level interrupt rises when the fill crosses a threshold chosen as a fraction of the capacity, and two request lines ask a DMA controller for single transfers or burst transfers.

A parameter sets the instance's direction. A receive instance is drained by the DMA and asks for service when data is waiting. A transmit instance is filled by the DMA and asks for service when space is free. Clearing the enable input shrinks the capacity to one entry, so the block acts as a plain holding register behind the engine's shift register.

Top module: `trig_fifo`

## Requirements
- R1: Bytes leave in the order they were accepted. `pop_data` takes the popped byte on the clock edge that accepts the pop, so it is valid from the next cycle.
- R2: `empty` is high exactly when no byte is held. `full` is high exactly when the number held equals the capacity, which is DEPTH (16) with `fifo_en`=1 and 1 with `fifo_en`=0.
- R3: A push while `full` is dropped and leaves the contents unchanged. It sets `overrun`, which then stays high until reset.
- R4: A pop while `empty` changes neither `pop_data` nor the fill.
- R5: A push and a pop in the same cycle, when the FIFO is neither full nor empty, both take effect and leave the fill unchanged.
- R6: `trig_sel` selects the threshold in entries: 0 gives 2, 1 gives 4, 2 gives 8, 3 gives 12 and 4 gives 14. The codes 5 to 7 give 8.
- R7: Receive instance (IS_TX=0) with `fifo_en`=1: `level_irq` and `dma_burst` are high when fill ≥ threshold. `dma_single` is high when fill ≥ 1.
- R8: Transmit instance (IS_TX=1) with `fifo_en`=1: `level_irq` is high when fill ≤ threshold. `dma_burst` is high when (DEPTH − fill) ≥ threshold. `dma_single` is high whenever the FIFO is not full.
- R9: With `fifo_en`=0, the receive instance drives `level_irq`, `dma_burst` and `dma_single` high exactly when one byte is held. The transmit instance drives all three high exactly when no byte is held.
- R10: After reset the FIFO is empty and not full, `overrun` is low and `pop_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1: full depth, 0: single holding register |
| trig_sel | input | 3 | Threshold code |
| push | input | 1 | Write request |
| push_data | input | 8 | Byte to write |
| pop | input | 1 | Read request |
| pop_data | output | 8 | Last byte popped |
| full | output | 1 | No free entry |
| empty | output | 1 | No byte held |
| overrun | output | 1 | Sticky: a push was dropped |
| level_irq | output | 1 | Threshold interrupt |
| dma_single | output | 1 | Single-transfer request |
| dma_burst | output | 1 | Burst request |

## Verification
A wrong fill count shows at the ports as a `full` or `empty` flag, or a threshold output, that differs from the reference in the cycle after the bad update. A pointer error shows as a wrong `pop_data` on the next pop that reaches the damaged entry, which can take up to sixteen pops. Receive and transmit instances run on the same stimulus and are compared on every cycle, at every threshold code and in single-entry mode.

// File: rtl/trig_fifo_pkg.sv
package trig_fifo_pkg;

    typedef enum logic [2:0] {
        TRIG_EIGHTH   = 3'd0,
        TRIG_QUARTER  = 3'd1,
        TRIG_HALF     = 3'd2,
        TRIG_3QUARTER = 3'd3,
        TRIG_7EIGHTH  = 3'd4
    } trig_code_e;

    // Threshold in entries for a given capacity; unknown codes fall back to half.
    function automatic int trig_entries(input logic [2:0] sel, input int depth);
        case (sel)
            TRIG_EIGHTH:   return depth / 8;
            TRIG_QUARTER:  return depth / 4;
            TRIG_HALF:     return depth / 2;
            TRIG_3QUARTER: return (depth * 3) / 4;
            TRIG_7EIGHTH:  return (depth * 7) / 8;
            default:       return depth / 2;
        endcase
    endfunction

endpackage

// File: rtl/trig_fifo_ram.sv
module trig_fifo_ram #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [PTR_W-1:0] raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/trig_fifo_ctrl.sv
module trig_fifo_ctrl #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] ram_rdata,
    output logic             ram_we,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] count,
    output logic [WIDTH-1:0] pop_data,
    output logic             full,
    output logic             empty,
    output logic             overrun
);
    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] cnt;
        logic             ovr;
        logic [WIDTH-1:0] rdata;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic [CNT_W-1:0] cap;
    logic push_ok, pop_ok;

    always_comb begin
        cap     = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
        full    = (st_q.cnt >= cap);
        empty   = (st_q.cnt == '0);
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        st_d    = st_q;
        if (push_ok)
            st_d.wptr = (st_q.wptr == PTR_W'(DEPTH - 1)) ? '0 : st_q.wptr + 1'b1;
        if (pop_ok) begin
            st_d.rptr  = (st_q.rptr == PTR_W'(DEPTH - 1)) ? '0 : st_q.rptr + 1'b1;
            st_d.rdata = ram_rdata;
        end
        if (push_ok && !pop_ok) st_d.cnt = st_q.cnt + 1'b1;
        if (pop_ok && !push_ok) st_d.cnt = st_q.cnt - 1'b1;
        if (push && full) st_d.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ram_we   = push_ok;
    assign wr_ptr   = st_q.wptr;
    assign rd_ptr   = st_q.rptr;
    assign count    = st_q.cnt;
    assign pop_data = st_q.rdata;
    assign overrun  = st_q.ovr;

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));
    assert_overrun_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    assert_empty_pop_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && empty) |=> ($stable(pop_data) && empty));
    assert_pushpop_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !empty && !full) |=> $stable(count));
endmodule

// File: rtl/trig_fifo_flags.sv
module trig_fifo_flags #(
    parameter int DEPTH = 16,
    parameter bit IS_TX = 1'b0,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             fifo_en,
    input  logic [2:0]       trig_sel,
    input  logic [CNT_W-1:0] count,
    output logic             level_irq,
    output logic             dma_single,
    output logic             dma_burst
);
    import trig_fifo_pkg::*;

    logic [CNT_W-1:0] thresh, free;

    always_comb begin
        thresh = CNT_W'(trig_entries(trig_sel, DEPTH));
        free   = CNT_W'(DEPTH) - count;
    end

    generate
        if (IS_TX) begin : g_tx
            always_comb begin
                if (fifo_en) begin
                    level_irq  = (count <= thresh);
                    dma_burst  = (free >= thresh);
                    dma_single = (count < CNT_W'(DEPTH));
                end else begin
                    level_irq  = (count == '0);
                    dma_burst  = (count == '0);
                    dma_single = (count == '0);
                end
            end
        end else begin : g_rx
            always_comb begin
                if (fifo_en) begin
                    level_irq  = (count >= thresh);
                    dma_burst  = (count >= thresh);
                    dma_single = (count != '0);
                end else begin
                    level_irq  = (count == CNT_W'(1));
                    dma_burst  = (count == CNT_W'(1));
                    dma_single = (count == CNT_W'(1));
                end
            end
        end
    endgenerate
endmodule

// File: rtl/trig_fifo.sv
module trig_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    parameter bit IS_TX = 1'b0,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [2:0]       trig_sel,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic             full,
    output logic             empty,
    output logic             overrun,
    output logic             level_irq,
    output logic             dma_single,
    output logic             dma_burst
);
    logic             ram_we;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [WIDTH-1:0] ram_rdata;
    logic [CNT_W-1:0] count;

    trig_fifo_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ram (
        .clk(clk), .we(ram_we), .waddr(wr_ptr), .wdata(push_data),
        .raddr(rd_ptr), .rdata(ram_rdata)
    );

    trig_fifo_ctrl #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .push(push), .pop(pop),
        .ram_rdata(ram_rdata), .ram_we(ram_we), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .count(count), .pop_data(pop_data), .full(full), .empty(empty),
        .overrun(overrun)
    );

    trig_fifo_flags #(.DEPTH(DEPTH), .IS_TX(IS_TX)) u_flags (
        .fifo_en(fifo_en), .trig_sel(trig_sel), .count(count),
        .level_irq(level_irq), .dma_single(dma_single), .dma_burst(dma_burst)
    );

    generate
        if (IS_TX) begin : g_chk_tx
            assert_tx_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
                fifo_en |-> (dma_single != full));
        end else begin : g_chk_rx
            assert_rx_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
                dma_single != empty);
        end
    endgenerate
endmodule

// File: tb/test_trig_fifo.sv
module test_trig_fifo;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fifo_en = 1'b1;
    logic [2:0] trig_sel = 3'd0;
    logic push = 1'b0, pop = 1'b0;
    logic [7:0] push_data = 8'd0;

    logic [7:0] rx_data, tx_data;
    logic rx_full, rx_empty, rx_ovr, rx_irq, rx_single, rx_burst;
    logic tx_full, tx_empty, tx_ovr, tx_irq, tx_single, tx_burst;

    int n_checks = 0;
    int n_errors = 0;

    byte unsigned q[$];
    byte unsigned last_byte = 0;
    bit ovr_m = 0;

    always #5 clk = ~clk;

    trig_fifo #(.IS_TX(1'b0)) i_trig_fifo (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
        .push(push), .push_data(push_data), .pop(pop), .pop_data(rx_data),
        .full(rx_full), .empty(rx_empty), .overrun(rx_ovr), .level_irq(rx_irq),
        .dma_single(rx_single), .dma_burst(rx_burst)
    );

    trig_fifo #(.IS_TX(1'b1)) i_trig_fifo_tx (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
        .push(push), .push_data(push_data), .pop(pop), .pop_data(tx_data),
        .full(tx_full), .empty(tx_empty), .overrun(tx_ovr), .level_irq(tx_irq),
        .dma_single(tx_single), .dma_burst(tx_burst)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic int th_of(input logic [2:0] s);
        case (s)
            3'd0: return 2;
            3'd1: return 4;
            3'd2: return 8;
            3'd3: return 12;
            3'd4: return 14;
            default: return 8;
        endcase
    endfunction

    task automatic compare_all();
        int n = q.size();
        int cap = fifo_en ? 16 : 1;
        int th = th_of(trig_sel);
        chk("R1 rx pop_data", rx_data, last_byte);
        chk("R1 tx pop_data", tx_data, last_byte);
        chk("R2 empty", rx_empty, n == 0);
        chk("R2 full", rx_full, n >= cap);
        chk("R2 tx full", tx_full, n >= cap);
        chk("R3 overrun", rx_ovr, ovr_m);
        chk("R3 tx overrun", tx_ovr, ovr_m);
        if (fifo_en) begin
            chk("R6 R7 rx level_irq", rx_irq, n >= th);
            chk("R7 rx dma_burst", rx_burst, n >= th);
            chk("R7 rx dma_single", rx_single, n >= 1);
            chk("R6 R8 tx level_irq", tx_irq, n <= th);
            chk("R8 tx dma_burst", tx_burst, (16 - n) >= th);
            chk("R8 tx dma_single", tx_single, n < 16);
        end else begin
            chk("R9 rx level_irq", rx_irq, n == 1);
            chk("R9 rx dma_burst", rx_burst, n == 1);
            chk("R9 rx dma_single", rx_single, n == 1);
            chk("R9 tx level_irq", tx_irq, n == 0);
            chk("R9 tx dma_burst", tx_burst, n == 0);
            chk("R9 tx dma_single", tx_single, n == 0);
        end
    endtask

    // One cycle: compare, drive, advance model to the next edge.
    task automatic step(input bit p, input bit r, input byte unsigned d);
        int cap;
        bit is_full, is_empty;
        @(negedge clk);
        compare_all();
        push = p; pop = r; push_data = d;
        cap = fifo_en ? 16 : 1;
        is_full = (q.size() >= cap);
        is_empty = (q.size() == 0);
        if (r && !is_empty) last_byte = q.pop_front();
        if (p && !is_full) q.push_back(d);
        if (p && is_full) ovr_m = 1;
    endtask

    task automatic run_mix(input int cycles, input int push_pct, input int pop_pct);
        for (int i = 0; i < cycles; i++)
            step(($urandom % 100) < push_pct, ($urandom % 100) < pop_pct, 8'($urandom));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 empty", rx_empty, 1);
        chk("R10 full", rx_full, 0);
        chk("R10 overrun", rx_ovr, 0);
        chk("R10 pop_data", rx_data, 0);
        rst_n = 1'b1;
        // R4: pop on empty changes nothing
        step(0, 1, 8'h00);
        step(0, 1, 8'h00);
        // R1 ordered fill and drain
        for (int i = 0; i < 5; i++) step(1, 0, 8'(8'hA0 + i));
        // R5 simultaneous push and pop mid-fill
        for (int i = 0; i < 4; i++) step(1, 1, 8'(8'h50 + i));
        for (int i = 0; i < 6; i++) step(0, 1, 8'h00);
        // R6 each threshold code, R3 overfill
        for (int s = 0; s < 8; s++) begin
            trig_sel = 3'(s);
            run_mix(40, 85, 15);
            run_mix(40, 15, 85);
        end
        for (int i = 0; i < 20; i++) step(0, 1, 8'h00);
        // R9 single-entry mode
        fifo_en = 1'b0;
        run_mix(120, 50, 50);
        step(0, 1, 8'h00);
        step(0, 1, 8'h00);
        fifo_en = 1'b1;
        run_mix(40, 50, 50);
        step(0, 0, 8'h00);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule